// File: doc/BRIEF.md
# Twin-Channel Interval Timer

This block is a register-mapped timer with two identical 32-bit channels. Each channel has a control word, a reload value and a live counter. Software preloads a channel by writing the reload value and then holding the control word's preset bit high. It starts the channel by clearing that bit and setting the run bit.

A running channel steps once per clock, either up or down. When it leaves its terminal value it sets a sticky event flag. It then either reloads and keeps going, or holds and stops. Software acknowledges an event by writing back the control word it just read, because a 1 written to the flag clears it. The flags of both channels, each gated by its own enable, are merged into a single registered interrupt line. A broadcast-start bit written to either channel starts both channels on the same clock edge.

Top module: `twin_timer`

## Requirements
- R1: Reset clears every control word, reload value and counter to zero and drives `irq` low.
- R2: Channel c has its control word at byte offset 0x10·c+0x0, its reload value at 0x10·c+0x4 and its counter at 0x10·c+0x8. Control bits 0..10 are mode, count-down, output enable, capture enable, auto-reload, preset, event-interrupt enable, run, event flag, pulse-width enable and broadcast start. Every bit except the event flag reads back as written, and bits 31..11 read 0.
- R3: While the preset bit (bit 5) reads 1, the counter is loaded from the reload value on every clock. Counting resumes only on the edge after the bit has been written back to 0.
- R4: With run set (bit 7) and preset clear, the counter decrements by one per clock when bit 1 is 1, and increments by one per clock when bit 1 is 0.
- R5: The terminal value is 0x00000000 when counting down and 0xFFFFFFFF when counting up. On the edge that leaves the terminal value, the event flag (bit 8) is set. With auto-reload (bit 4) set, the counter takes the reload value and keeps running.
- R6: With auto-reload clear, that same edge sets the event flag and clears the run bit, and the counter holds the terminal value.
- R7: Writing 1 to bit 8 of a control word clears the event flag, and writing 0 leaves it unchanged. A set and a clear on the same edge leave the flag set.
- R8: With run clear, the counter keeps its value.
- R9: `irq` is a register. It goes high one clock after any channel has both its event flag and its event-interrupt enable (bit 6) at 1, and it stays low otherwise.
- R10: A control-word write with bit 10 set also sets the run bit of the other channel on the same edge.
- R11: Reads from unmapped offsets return zero, and writes to the counter offsets have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 5 | Byte address of the register |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, valid in the same cycle |
| irq | output | 1 | Combined registered interrupt |

## Verification
The case that is hardest to reach from the ports is an up-counting channel hitting 0xFFFFFFFF. Counting there from reset would take 2^32 clocks. The stimulus instead presets the counter to 0xFFFFFFFD through the reload/preset sequence, so the channel reaches terminal count a few clocks after it starts. From there the bench checks that the channel stops and that the held value, the cleared run bit and the set flag are all visible. The same preset route reaches the broadcast start, which restarts a channel that is parked on its terminal value.

// File: rtl/twin_timer_pkg.sv
package twin_timer_pkg;

    localparam int CTRL_W = 11;

    // control word, bit 10 down to bit 0
    typedef struct packed {
        logic bcast;    // 10 start every channel
        logic pwm_en;   // 9  stored only
        logic flag;     // 8  sticky event, write 1 to clear
        logic run;      // 7
        logic ev_ie;    // 6
        logic preset;   // 5
        logic arld;     // 4
        logic cap_en;   // 3  stored only
        logic out_en;   // 2  stored only
        logic down;     // 1
        logic mode;     // 0  stored only
    } ctrl_t;

    localparam int OFS_CTRL = 4'h0;
    localparam int OFS_LOAD = 4'h4;
    localparam int OFS_CNT  = 4'h8;

endpackage

// File: rtl/twin_timer_chan.sv
module twin_timer_chan
    import twin_timer_pkg::*;
#(
    parameter int W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we_i,
    input  logic              ld_we_i,
    input  logic              bcast_i,
    input  logic [W-1:0]      wdata_i,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic [W-1:0]      ldv_o,
    output logic [W-1:0]      cnt_o
);

    typedef struct packed {
        ctrl_t        ctrl;
        logic [W-1:0] ldv;
        logic [W-1:0] cnt;
    } chan_t;

    chan_t s_d, s_q;
    ctrl_t wr;
    logic [W-1:0] term;
    logic at_term, roll;

    always_comb begin
        s_d     = s_q;
        wr      = ctrl_t'(wdata_i[CTRL_W-1:0]);
        term    = s_q.ctrl.down ? '0 : '1;
        at_term = (s_q.cnt == term);
        roll    = s_q.ctrl.run && !s_q.ctrl.preset && at_term;

        if (s_q.ctrl.preset) begin
            s_d.cnt = s_q.ldv;
        end else if (s_q.ctrl.run) begin
            if (at_term) begin
                if (s_q.ctrl.arld) s_d.cnt = s_q.ldv;
            end else if (s_q.ctrl.down) begin
                s_d.cnt = s_q.cnt - 1'b1;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end

        if (ld_we_i) s_d.ldv = wdata_i;

        if (ctrl_we_i) begin
            s_d.ctrl      = wr;
            s_d.ctrl.run  = wr.run | wr.bcast;
            s_d.ctrl.flag = s_q.ctrl.flag & ~wr.flag;
        end else if (roll && !s_q.ctrl.arld) begin
            s_d.ctrl.run = 1'b0;
        end

        if (bcast_i) s_d.ctrl.run  = 1'b1;
        if (roll)    s_d.ctrl.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ctrl_o = s_q.ctrl;
    assign ldv_o  = s_q.ldv;
    assign cnt_o  = s_q.cnt;

endmodule

// File: rtl/twin_timer_regmap.sv
module twin_timer_regmap
    import twin_timer_pkg::*;
#(
    parameter int N_CH   = 2,
    parameter int W      = 32,
    parameter int ADDR_W = 5
) (
    input  logic [ADDR_W-1:0]              addr_i,
    input  logic                           we_i,
    input  logic [W-1:0]                   wdata_i,
    input  logic [N_CH-1:0][CTRL_W-1:0]    ctrl_i,
    input  logic [N_CH-1:0][W-1:0]         ldv_i,
    input  logic [N_CH-1:0][W-1:0]         cnt_i,
    output logic [N_CH-1:0]                ctrl_we_o,
    output logic [N_CH-1:0]                ld_we_o,
    output logic                           bcast_o,
    output logic [W-1:0]                   rdata_o
);

    int         sel;
    logic [3:0] ofs;

    always_comb begin
        sel     = int'(addr_i >> 4);
        ofs     = addr_i[3:0];
        rdata_o = '0;
        for (int c = 0; c < N_CH; c++) begin
            ctrl_we_o[c] = we_i && (sel == c) && (ofs == 4'(OFS_CTRL));
            ld_we_o[c]   = we_i && (sel == c) && (ofs == 4'(OFS_LOAD));
            if (sel == c) begin
                case (ofs)
                    4'(OFS_CTRL): rdata_o[CTRL_W-1:0] = ctrl_i[c];
                    4'(OFS_LOAD): rdata_o = ldv_i[c];
                    4'(OFS_CNT):  rdata_o = cnt_i[c];
                    default:      rdata_o = '0;
                endcase
            end
        end
        bcast_o = (|ctrl_we_o) && wdata_i[CTRL_W-1];
    end

endmodule

// File: rtl/twin_timer.sv
module twin_timer
    import twin_timer_pkg::*;
#(
    parameter int N_CH   = 2,
    parameter int W      = 32,
    localparam int ADDR_W = $clog2(N_CH) + 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    output logic              irq
);

    logic [N_CH-1:0][CTRL_W-1:0] ctrl_w;
    logic [N_CH-1:0][W-1:0]      ldv_w;
    logic [N_CH-1:0][W-1:0]      cnt_w;
    logic [N_CH-1:0]             ctrl_we, ld_we;
    logic                        bcast;
    logic                        irq_d, irq_q;

    twin_timer_regmap #(.N_CH(N_CH), .W(W), .ADDR_W(ADDR_W)) u_map (
        .addr_i   (bus_addr),
        .we_i     (bus_we),
        .wdata_i  (bus_wdata),
        .ctrl_i   (ctrl_w),
        .ldv_i    (ldv_w),
        .cnt_i    (cnt_w),
        .ctrl_we_o(ctrl_we),
        .ld_we_o  (ld_we),
        .bcast_o  (bcast),
        .rdata_o  (bus_rdata)
    );

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        twin_timer_chan #(.W(W)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .ctrl_we_i(ctrl_we[c]),
            .ld_we_i  (ld_we[c]),
            .bcast_i  (bcast),
            .wdata_i  (bus_wdata),
            .ctrl_o   (ctrl_w[c]),
            .ldv_o    (ldv_w[c]),
            .cnt_o    (cnt_w[c])
        );
    end

    always_comb begin
        irq_d = 1'b0;
        for (int c = 0; c < N_CH; c++) begin
            irq_d = irq_d | (ctrl_w[c][8] & ctrl_w[c][6]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= irq_d;
    end

    assign irq = irq_q;

endmodule

// File: rtl/twin_timer_checker.sv
module twin_timer_checker
    import twin_timer_pkg::*;
#(
    parameter int N_CH = 2,
    parameter int W    = 32
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        irq,
    input logic [N_CH-1:0][CTRL_W-1:0] ctrl,
    input logic [N_CH-1:0][W-1:0]      cnt,
    input logic [N_CH-1:0][W-1:0]      ldv
);

    for (genvar i = 0; i < N_CH; i++) begin : g_chk
        AST_PRESET_FORCES: assert property (@(posedge clk) disable iff (!rst_n)
            ctrl[i][5] |=> cnt[i] == $past(ldv[i])); // R3

        AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
            (ctrl[i][7] && !ctrl[i][5] && cnt[i] != (ctrl[i][1] ? {W{1'b0}} : {W{1'b1}}))
            |=> cnt[i] == ($past(ctrl[i][1]) ? $past(cnt[i]) - 1'b1 : $past(cnt[i]) + 1'b1)); // R4

        AST_ROLL_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
            (ctrl[i][7] && !ctrl[i][5] && cnt[i] == (ctrl[i][1] ? {W{1'b0}} : {W{1'b1}}))
            |=> ctrl[i][8]); // R5

        AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            (!ctrl[i][7] && !ctrl[i][5]) |=> $stable(cnt[i])); // R8

        AST_IRQ_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
            (ctrl[i][8] && ctrl[i][6]) |=> irq); // R9
    end

endmodule

bind twin_timer twin_timer_checker #(.N_CH(N_CH), .W(W)) u_chk (
    .clk  (clk),
    .rst_n(rst_n),
    .irq  (irq),
    .ctrl (ctrl_w),
    .cnt  (cnt_w),
    .ldv  (ldv_w)
);

// File: tb/tb_twin_timer.sv
module tb_twin_timer;

    localparam int OP_WR = 0, OP_RD = 1, OP_IRQ = 2, OP_IDLE = 3;

    typedef struct packed {
        logic [1:0]  op;
        logic [4:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 40;
    localparam vec_t VEC [NV] = '{
        '{2'(OP_WR),  5'h04, 32'h3,        32'h0,        4'd3},  // reload 3
        '{2'(OP_WR),  5'h00, 32'h20,       32'h0,        4'd3},  // preset
        '{2'(OP_RD),  5'h08, 32'h0,        32'h0,        4'd3},  // R3 not yet loaded
        '{2'(OP_WR),  5'h00, 32'h1D2,      32'h0,        4'd4},  // down, arld, ie, run
        '{2'(OP_RD),  5'h08, 32'h0,        32'h3,        4'd3},  // R3 preset value
        '{2'(OP_RD),  5'h08, 32'h0,        32'h2,        4'd4},  // R4 down step
        '{2'(OP_RD),  5'h08, 32'h0,        32'h1,        4'd4},  // R4
        '{2'(OP_RD),  5'h08, 32'h0,        32'h0,        4'd4},  // R4 terminal
        '{2'(OP_RD),  5'h00, 32'h0,        32'h1D2,      4'd5},  // R5 flag set
        '{2'(OP_IRQ), 5'h00, 32'h0,        32'h1,        4'd9},  // R9 irq one clock later
        '{2'(OP_WR),  5'h00, 32'h1D2,      32'h0,        4'd7},  // ack by write-back
        '{2'(OP_RD),  5'h00, 32'h0,        32'hD2,       4'd7},  // R7 cleared
        '{2'(OP_IRQ), 5'h00, 32'h0,        32'h0,        4'd9},  // R9 low after ack
        '{2'(OP_RD),  5'h00, 32'h0,        32'h1D2,      4'd5},  // R5 reload kept running
        '{2'(OP_WR),  5'h00, 32'hD2,       32'h0,        4'd7},  // write 0 to flag
        '{2'(OP_RD),  5'h00, 32'h0,        32'h1D2,      4'd7},  // R7 unchanged
        '{2'(OP_WR),  5'h00, 32'h152,      32'h0,        4'd8},  // stop and ack
        '{2'(OP_IDLE),5'h00, 32'h3,        32'h0,        4'd8},
        '{2'(OP_RD),  5'h08, 32'h0,        32'h2,        4'd8},  // R8 frozen
        '{2'(OP_WR),  5'h08, 32'h1234,     32'h0,        4'd11}, // counter write
        '{2'(OP_RD),  5'h08, 32'h0,        32'h2,        4'd11}, // R11 ignored
        '{2'(OP_RD),  5'h04, 32'h0,        32'h3,        4'd2},  // R2 reload readback
        '{2'(OP_WR),  5'h14, 32'hFFFFFFFD, 32'h0,        4'd6},  // ch1 near terminal
        '{2'(OP_WR),  5'h10, 32'h20,       32'h0,        4'd6},
        '{2'(OP_IDLE),5'h00, 32'h1,        32'h0,        4'd6},
        '{2'(OP_WR),  5'h10, 32'h80,       32'h0,        4'd6},  // up, no arld
        '{2'(OP_RD),  5'h18, 32'h0,        32'hFFFFFFFD, 4'd3},  // R3
        '{2'(OP_IDLE),5'h00, 32'h2,        32'h0,        4'd4},
        '{2'(OP_RD),  5'h18, 32'h0,        32'hFFFFFFFF, 4'd4},  // R4 up step
        '{2'(OP_RD),  5'h10, 32'h0,        32'h100,      4'd6},  // R6 run cleared, flag
        '{2'(OP_RD),  5'h18, 32'h0,        32'hFFFFFFFF, 4'd6},  // R6 held
        '{2'(OP_IRQ), 5'h00, 32'h0,        32'h0,        4'd9},  // R9 gated by enable
        '{2'(OP_WR),  5'h10, 32'h30D,      32'h0,        4'd2},
        '{2'(OP_RD),  5'h10, 32'h0,        32'h20D,      4'd2},  // R2 plain bits
        '{2'(OP_RD),  5'h0C, 32'h0,        32'h0,        4'd11}, // R11 unmapped
        '{2'(OP_RD),  5'h1C, 32'h0,        32'h0,        4'd11}, // R11 unmapped
        '{2'(OP_WR),  5'h10, 32'h400,      32'h0,        4'd10}, // broadcast start
        '{2'(OP_RD),  5'h10, 32'h0,        32'h480,      4'd10}, // R10 own run
        '{2'(OP_RD),  5'h00, 32'h0,        32'hD2,       4'd10}, // R10 peer run
        '{2'(OP_RD),  5'h08, 32'h0,        32'h0,        4'd10}  // R10 peer counting
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;
    int          checks = 0;
    int          failures = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    twin_timer dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_we   (bus_we),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .irq      (irq)
    );

    task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [4:0] a, input logic [31:0] exp, input int req);
        @(negedge clk);
        bus_we = 1'b0;
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        for (int a = 0; a < 32; a += 4) rd(5'(a), 32'h0, 1);
        check(1, {31'b0, irq}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            bus_we = 1'b0;
            bus_addr = VEC[i].addr;
            bus_wdata = VEC[i].data;
            case (int'(VEC[i].op))
                OP_WR:   bus_we = 1'b1;
                OP_RD:   begin #1; check(int'(VEC[i].req), bus_rdata, VEC[i].exp); end
                OP_IRQ:  begin #1; check(int'(VEC[i].req), {31'b0, irq}, VEC[i].exp); end
                default: repeat (int'(VEC[i].data) - 1) @(negedge clk);
            endcase
        end

        // R1 reset in mid-run clears everything
        @(negedge clk);
        bus_we = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        rd(5'h00, 32'h0, 1);
        rd(5'h04, 32'h0, 1);
        rd(5'h08, 32'h0, 1);
        rd(5'h10, 32'h0, 1);
        check(1, {31'b0, irq}, 32'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule